// File: doc/BRIEF.md
# Edge-Qualified Interrupt Latch Unit

This block watches five asynchronous status levels: ID-ground, session-end, session-valid, VBUS-valid and host-disconnect. Each level passes through a two-flop synchroniser and then an edge detector. Every source has its own rising-edge enable and falling-edge enable. An enabled edge sets a sticky bit in a latch register and pulses an event-request output for one cycle. A link controller reads the latch register to learn which sources changed. The read also clears the latch in one step. A status register gives the present, synchronised level of each source.

Two sources have extra qualification. Host-disconnect edges count only when the block is in host mode, which means both the DP and DM pulldown controls are 1. The ID-ground view is frozen while the ID pullup control is 0. It also stays frozen for a programmable number of clock cycles after the pullup turns on, which lets the pin settle. The register port has one address bus, separate read and write strobes, and read data that is registered.

Top module: `usb_evt_latch`

## Requirements
- R1: Every register uses the same bit positions: bit 4 ID-ground, bit 3 session-end, bit 2 session-valid, bit 1 VBUS-valid, bit 0 host-disconnect. Bits 7:5 always read 0. Reading an address that is not mapped returns 0x00.
- R2: After reset, the rise enable reads 0x1F, the fall enable reads 0x1F, the latch and status read 0x00, and the event request is 0.
- R3: The rise enable sits at 0x0D with a set alias at 0x0E and a clear alias at 0x0F. The fall enable sits at 0x10 with a set alias at 0x11 and a clear alias at 0x12. A set alias turns on only the bits written as 1. A clear alias turns off only the bits written as 1. Reading any alias returns the register.
- R4: An edge sets its latch bit only when the enable for that source and that direction is 1. A masked edge leaves the latch and the event request unchanged.
- R5: A read strobe puts data on the read-data output at the next clock edge. A read of the latch at 0x14 returns the whole latch and clears it.
- R6: An edge that sets the latch in the same cycle as a latch read is kept. The next latch read returns it.
- R7: The event request is high for exactly one cycle for each cycle in which at least one enabled edge is taken. That is the same cycle in which the latch bits rise.
- R8: Host-disconnect edges are taken only while both pulldown controls are 1.
- R9: The ID-ground view is frozen while the pullup control is 0, and for HOLD_CYCLES cycles after the pullup control goes to 1. While the view is frozen, no ID event is taken. If the level changed during the freeze, the change counts as an edge when the view updates.
- R10: The status register at 0x13 returns the synchronised source levels. An input change appears there no sooner than three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 5 | Asynchronous source levels, in the R1 bit order |
| dp_pulldown_i | input | 1 | DP pulldown control, used for host-mode gating |
| dm_pulldown_i | input | 1 | DM pulldown control, used for host-mode gating |
| id_pullup_i | input | 1 | ID pullup control, used for the ID freeze |
| reg_addr_i | input | 8 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| evt_req_o | output | 1 | One-cycle event request |

## Verification
The bench lines up a source edge with a latch read in the same clock. A design that clears after the merge would lose that edge, so the second read would come back 0. Host-disconnect is toggled both in and out of host mode. A design without gating would set bit 0 and raise an event when no pulldowns are active. The ID source is checked both just inside and just past the freeze window. An early release, or no release at all, shows up in both the status and the latch. A random phase sweeps the masks against mixed rising and falling edges and checks the alias arithmetic. This catches swapped rise and fall masks, and reserved bits that leak through.

// File: rtl/usb_evt_latch_pkg.sv
// Shared constants for the edge-qualified interrupt latch unit.
// Assumes an 8-bit register address space and a five-source layout.
package usb_evt_latch_pkg;
    localparam int NSRC     = 5;
    localparam int B_ID     = 4;
    localparam int B_SESSEND = 3;
    localparam int B_SESSVLD = 2;
    localparam int B_VBUS   = 1;
    localparam int B_HDISC  = 0;

    localparam logic [7:0] A_RISE     = 8'h0D;
    localparam logic [7:0] A_RISE_SET = 8'h0E;
    localparam logic [7:0] A_RISE_CLR = 8'h0F;
    localparam logic [7:0] A_FALL     = 8'h10;
    localparam logic [7:0] A_FALL_SET = 8'h11;
    localparam logic [7:0] A_FALL_CLR = 8'h12;
    localparam logic [7:0] A_STATUS   = 8'h13;
    localparam logic [7:0] A_LATCH    = 8'h14;
endpackage

// File: rtl/usb_evt_sync.sv
// Two-flop synchroniser, one chain per bit.
// Assumes each bit is an independent slow level, so no bus coherency is needed.
module usb_evt_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, sync_q;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end
        assign q_o[g] = sync_q;
    end
endmodule

// File: rtl/usb_evt_holdoff.sv
// Hold-off timer for the ID source.
// open_o is 1 only after the pullup has been on for HOLD_CYCLES cycles in a row.
// Assumes the pullup control is synchronous to clk.
module usb_evt_holdoff #(
    parameter int HOLD_CYCLES = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pullup_i,
    output logic open_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count the cycles since the pullup turned on, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !pullup_i) cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign open_o = pullup_i && (cnt_q == LIMIT);

    p_closed_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pullup_i |=> (cnt_q == '0));
endmodule

// File: rtl/usb_evt_edge.sv
// Rising and falling edge detector on an already synchronised vector.
// Assumes the input is registered in the clk domain.
module usb_evt_edge #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    // Keep the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/usb_evt_latch.sv
// Edge-qualified interrupt latch unit: synchronises five status levels, applies
// the rise/fall masks, host-mode gating and the ID freeze, keeps clear-on-read
// latches and pulses an event request. Assumes single-cycle read/write strobes
// and that the control inputs (pulldowns, pullup) are synchronous to clk.
module usb_evt_latch
    import usb_evt_latch_pkg::*;
#(
    parameter int HOLD_CYCLES = 3_000_000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            dp_pulldown_i,
    input  logic            dm_pulldown_i,
    input  logic            id_pullup_i,
    input  logic [7:0]      reg_addr_i,
    input  logic            reg_wr_i,
    input  logic            reg_rd_i,
    input  logic [7:0]      reg_wdata_i,
    output logic [7:0]      reg_rdata_o,
    output logic            evt_req_o
);
    localparam int PAD = 8 - NSRC;

    logic [NSRC-1:0] sync_w, view_q, rise_w, fall_w, evt_w;
    logic [NSRC-1:0] rise_en_q, fall_en_q, latch_q;
    logic [NSRC-1:0] wbits;
    logic            id_open, host_mode;
    logic            unused_wbits;

    assign wbits        = reg_wdata_i[NSRC-1:0];
    assign unused_wbits = ^reg_wdata_i[7:NSRC];
    assign host_mode    = dp_pulldown_i && dm_pulldown_i;

    usb_evt_sync #(.W(NSRC)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(sync_w));

    usb_evt_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
        .clk(clk), .rst_n(rst_n), .pullup_i(id_pullup_i), .open_o(id_open));

    // Visible levels: the ID bit follows the synchroniser only while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view_q <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (i != B_ID || id_open) view_q[i] <= sync_w[i];
            end
        end
    end

    usb_evt_edge #(.W(NSRC)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl_i(view_q), .rise_o(rise_w), .fall_o(fall_w));

    // Mask the edges and gate host-disconnect by host mode.
    always_comb begin
        evt_w = (rise_w & rise_en_q) | (fall_w & fall_en_q);
        if (!host_mode) evt_w[B_HDISC] = 1'b0;
    end

    // Mask registers with direct, set and clear aliases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_q <= '1;
            fall_en_q <= '1;
        end else if (reg_wr_i) begin
            case (reg_addr_i)
                A_RISE:     rise_en_q <= wbits;
                A_RISE_SET: rise_en_q <= rise_en_q | wbits;
                A_RISE_CLR: rise_en_q <= rise_en_q & ~wbits;
                A_FALL:     fall_en_q <= wbits;
                A_FALL_SET: fall_en_q <= fall_en_q | wbits;
                A_FALL_CLR: fall_en_q <= fall_en_q & ~wbits;
                default: ;
            endcase
        end
    end

    // Sticky latch; a read replaces it with only this cycle's new events.
    always_ff @(posedge clk) begin
        if (!rst_n)                                latch_q <= '0;
        else if (reg_rd_i && reg_addr_i == A_LATCH) latch_q <= evt_w;
        else                                       latch_q <= latch_q | evt_w;
    end

    // One-cycle event request, aligned with the latch update.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_req_o <= 1'b0;
        else        evt_req_o <= |evt_w;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata_o <= '0;
        end else if (reg_rd_i) begin
            case (reg_addr_i)
                A_RISE, A_RISE_SET, A_RISE_CLR: reg_rdata_o <= {{PAD{1'b0}}, rise_en_q};
                A_FALL, A_FALL_SET, A_FALL_CLR: reg_rdata_o <= {{PAD{1'b0}}, fall_en_q};
                A_STATUS:                       reg_rdata_o <= {{PAD{1'b0}}, view_q};
                A_LATCH:                        reg_rdata_o <= {{PAD{1'b0}}, latch_q};
                default:                        reg_rdata_o <= '0;
            endcase
        end
    end

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[7:NSRC] == '0);
    p_latch_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == A_LATCH) |=> (reg_rdata_o[NSRC-1:0] == $past(latch_q)));
    p_req_with_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_req_o |-> (latch_q != '0));
    p_host_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q[B_HDISC]) |-> $past(host_mode));
    p_id_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !id_open |=> $stable(view_q[B_ID]));
endmodule

// File: tb/usb_evt_latch_tb_top.sv
module usb_evt_latch_tb_top;
    localparam int HOLD = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src = '0;
    logic       dp_pd = 1'b0, dm_pd = 1'b0, id_pu = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata;
    logic       req;

    int checks = 0, fails = 0, req_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usb_evt_latch #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .dp_pulldown_i(dp_pd),
        .dm_pulldown_i(dm_pd), .id_pullup_i(id_pu), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .evt_req_o(req));

    always @(posedge clk) if (rst_n && req) req_cnt++;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [7:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    function automatic logic [4:0] exp_evt(logic [4:0] p, logic [4:0] n,
            logic [4:0] re, logic [4:0] fe, logic host);
        logic [4:0] e;
        e = ((n & ~p) & re) | ((~n & p) & fe);
        if (!host) e[0] = 1'b0;
        return e;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [4:0] prev, nxt, re, fe, e;
        logic host;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R2 event request after reset", int'(req), 0);
        rreg(8'h0D, d); check("R2 rise enable reset", d, 8'h1F);
        rreg(8'h10, d); check("R2 fall enable reset", d, 8'h1F);
        rreg(8'h14, d); check("R2 latch reset", d, 8'h00);
        rreg(8'h13, d); check("R2 status reset", d, 8'h00);
        rreg(8'h33, d); check("R1 unmapped address", d, 8'h00);

        // R3 alias arithmetic, reserved write bits dropped
        wreg(8'h0D, 8'h00); wreg(8'h0E, 8'hA5); wreg(8'h0F, 8'h01);
        rreg(8'h0F, d); check("R3 rise set/clear alias", d, 8'h04);
        wreg(8'h10, 8'h13); wreg(8'h11, 8'h08); wreg(8'h12, 8'h10);
        rreg(8'h11, d); check("R3 fall set/clear alias", d, 8'h0B);
        wreg(8'h0D, 8'h1F); wreg(8'h10, 8'h1F);

        // R9 ID frozen while pullup is off
        src[4] = 1'b1;
        repeat (10) @(negedge clk);
        rreg(8'h13, d); check("R9 ID frozen, pullup off", d, 8'h00);
        @(negedge clk); id_pu = 1'b1; req_cnt = 0;
        repeat (25) @(negedge clk);
        rreg(8'h13, d); check("R9 ID still frozen in window", d, 8'h00);
        rreg(8'h14, d); check("R9 no ID event in window", d, 8'h00);
        repeat (30) @(negedge clk);
        rreg(8'h13, d); check("R9 ID released status", d, 8'h10);
        rreg(8'h14, d); check("R9 ID edge at release", d, 8'h10);
        check("R7 one request at release", req_cnt, 1);

        // R10 status latency
        @(negedge clk); src[2] = 1'b1; addr = 8'h13; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check("R10 status not yet updated", rdata, 8'h10);
        repeat (4) @(negedge clk);
        rreg(8'h13, d); check("R10 status updated", d, 8'h14);
        rreg(8'h14, d); check("R4 session-valid rise latched", d, 8'h04);

        // R8 host gating
        dp_pd = 1'b1; dm_pd = 1'b0; req_cnt = 0;
        @(negedge clk); src[0] = 1'b1;
        repeat (8) @(negedge clk);
        rreg(8'h14, d); check("R8 host-disconnect gated off", d, 8'h00);
        check("R8 no request when gated", req_cnt, 0);
        dm_pd = 1'b1;
        @(negedge clk); src[0] = 1'b0;
        repeat (8) @(negedge clk);
        rreg(8'h14, d); check("R8 host-disconnect fall in host mode", d, 8'h01);

        // R4 masked edge
        wreg(8'h12, 8'h02); req_cnt = 0;
        @(negedge clk); src[1] = 1'b1; @(negedge clk); src[1] = 1'b0;
        repeat (8) @(negedge clk);
        rreg(8'h14, d); check("R4 masked fall ignored, rise latched", d, 8'h02);
        check("R7 one request for rise only", req_cnt, 1);
        wreg(8'h11, 8'h02);

        // R6 edge in the same cycle as a latch read
        rreg(8'h14, d); req_cnt = 0;
        @(negedge clk); src[3] = 1'b1;
        repeat (3) @(negedge clk);
        addr = 8'h14; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check("R6 colliding read sees old latch", rdata, 8'h00);
        rreg(8'h14, d); check("R6 colliding edge kept", d, 8'h08);
        rreg(8'h14, d); check("R5 latch cleared after read", d, 8'h00);
        check("R7 request count at collision", req_cnt, 1);

        // Random phase
        prev = src;
        for (int it = 0; it < 40; it++) begin
            re = 5'($urandom); fe = 5'($urandom); host = 1'($urandom);
            nxt = 5'($urandom);
            wreg(8'h0D, {3'b111, re}); wreg(8'h10, {3'b101, fe});
            dp_pd = host; dm_pd = host;
            rreg(8'h14, d);
            req_cnt = 0;
            @(negedge clk); src = nxt;
            repeat (8) @(negedge clk);
            e = exp_evt(prev, nxt, re, fe, host);
            rreg(8'h14, d); check("R4 random latch", d, {3'b000, e});
            rreg(8'h13, d); check("R10 random status", d, {3'b000, nxt});
            check("R7 random request count", req_cnt, (e != 0) ? 1 : 0);
            prev = nxt;
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule